// File: doc/BRIEF.md
# Track-Mode Bidirectional Bus Buffer

This block turns a whole byte-wide port into a bidirectional buffer between a local multiplexed address/data bus and an external shared resource or host processor. No direction register is involved. The direction is decided afresh from the current inputs: the address strobe, the read and write strobes, and three decoded address-range selects. These selects are address-out, write-data-out and read-data-in, and the address decoder that produces them lies outside the block.

Each pin is driven through a drive value and an enable pair. The block produces one pair on the port side and one pair on the local-bus side. The pad circuitry combines them. A mode input chooses the strobe convention: separate active-low read and write strobes, or a combined read/write line qualified by an active-high data strobe. A track enable input hands the pins back to other port functions when it is low.

The control path is purely combinational, so the outputs follow the inputs with no clock.

Top module: `trk_bus_buffer`

## Requirements
- R1: With `trk_en`=1, `sel_addr` and `as_stb` both high make `port_oe`=1, `port_out`=`bus_in`, and `bus_oe`=0.
- R2: With `bus_mode`=0 (separate strobes), a read cycle is `rd_n`=0. A read cycle with `sel_rdin`=1 and R1 not applying makes `bus_oe`=1, `bus_out`=`port_in`, and `port_oe`=0.
- R3: With `bus_mode`=0, a write cycle is `wr_n`=0. A write cycle with `sel_wrout`=1, and neither R1 nor R2 applying, makes `port_oe`=1, `port_out`=`bus_in`, and `bus_oe`=0.
- R4: With `bus_mode`=1 (combined), a read cycle is `ds`=1 with `rnw`=1, and a write cycle is `ds`=1 with `rnw`=0. `rd_n` and `wr_n` have no effect in this mode, and `ds` and `rnw` have no effect when `bus_mode`=0.
- R5: When several conditions hold at once, the address-out condition wins first, then the read-in condition, then the write-out condition.
- R6: When none of the conditions holds, `port_oe`=0 and `bus_oe`=0, and both drive values are all zeros.
- R7: With `trk_en`=0, both enables are 0 and both drive values are zero, whatever the other inputs are.
- R8: `port_oe` and `bus_oe` are never 1 together. A single enable covers all port pins.
- R9: The outputs depend only on the present inputs, with no stored state, so repeating an input vector always gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| trk_en | input | 1 | Track mode enable |
| bus_mode | input | 1 | Strobe convention: 0 separate RD/WR, 1 combined R/W with data strobe |
| as_stb | input | 1 | Address strobe, active high |
| rd_n | input | 1 | Separate read strobe, active low |
| wr_n | input | 1 | Separate write strobe, active low |
| ds | input | 1 | Combined-mode data strobe, active high |
| rnw | input | 1 | Combined-mode direction, 1 = read |
| sel_addr | input | 1 | Address-out range select |
| sel_wrout | input | 1 | Write-data-out range select |
| sel_rdin | input | 1 | Read-data-in range select |
| bus_in | input | W | Value on the local address/data bus |
| port_in | input | W | Value on the port pins |
| port_out | output | W | Port-side drive value |
| port_oe | output | 1 | Port-side drive enable |
| bus_out | output | W | Local-bus drive value |
| bus_oe | output | 1 | Local-bus drive enable |

## Verification
The hardest case to reach is a cycle where the conditions overlap. One example is a read strobe and a write strobe both active, with their selects high, while the address strobe is also up. Another is a strobe of the convention not in use toggling while the other convention's strobe is active. In ordinary bus traffic neither case occurs, so priority and mode-isolation faults would stay hidden. The stimulus walks all 1024 combinations of the ten control inputs under two data patterns, which drives every overlap and every ignored-strobe case. Each result is compared with a model built from the priority rules.

// File: rtl/trk_pkg.sv
package trk_pkg;

    typedef enum logic [1:0] {
        DIR_IDLE   = 2'd0,
        DIR_ADDR   = 2'd1,
        DIR_RDIN   = 2'd2,
        DIR_WROUT  = 2'd3
    } trk_dir_e;

    typedef struct packed {
        logic rd_cyc;
        logic wr_cyc;
    } trk_cyc_t;

    typedef struct packed {
        trk_dir_e dir;
        logic     drive_port;
        logic     drive_bus;
    } trk_ctl_t;

endpackage

// File: rtl/trk_cycle_qual.sv
module trk_cycle_qual
    import trk_pkg::*;
(
    input  logic     bus_mode,
    input  logic     rd_n,
    input  logic     wr_n,
    input  logic     ds,
    input  logic     rnw,
    output trk_cyc_t cyc
);

    trk_cyc_t cyc_d;

    always_comb begin
        cyc_d = '0;
        if (bus_mode) begin
            cyc_d.rd_cyc = ds & rnw;
            cyc_d.wr_cyc = ds & ~rnw;
        end else begin
            cyc_d.rd_cyc = ~rd_n;
            cyc_d.wr_cyc = ~wr_n;
        end
    end

    assign cyc = cyc_d;

endmodule

// File: rtl/trk_dir_arb.sv
module trk_dir_arb
    import trk_pkg::*;
(
    input  logic     trk_en,
    input  logic     as_stb,
    input  trk_cyc_t cyc,
    input  logic     sel_addr,
    input  logic     sel_wrout,
    input  logic     sel_rdin,
    output trk_ctl_t ctl
);

    trk_ctl_t ctl_d;

    always_comb begin
        ctl_d = '{dir: DIR_IDLE, drive_port: 1'b0, drive_bus: 1'b0};
        if (trk_en) begin
            if (sel_addr && as_stb) begin
                ctl_d.dir = DIR_ADDR;
            end else if (sel_rdin && cyc.rd_cyc) begin
                ctl_d.dir = DIR_RDIN;
            end else if (sel_wrout && cyc.wr_cyc) begin
                ctl_d.dir = DIR_WROUT;
            end
        end
        ctl_d.drive_port = (ctl_d.dir == DIR_ADDR) || (ctl_d.dir == DIR_WROUT);
        ctl_d.drive_bus  = (ctl_d.dir == DIR_RDIN);
    end

    assign ctl = ctl_d;

endmodule

// File: rtl/trk_data_path.sv
module trk_data_path #(
    parameter int W = 8
) (
    input  logic         drive_port,
    input  logic         drive_bus,
    input  logic [W-1:0] bus_in,
    input  logic [W-1:0] port_in,
    output logic [W-1:0] port_out,
    output logic [W-1:0] bus_out
);

    for (genvar i = 0; i < W; i++) begin : g_lane
        assign port_out[i] = drive_port & bus_in[i];
        assign bus_out[i]  = drive_bus & port_in[i];
    end

endmodule

// File: rtl/trk_bus_buffer.sv
module trk_bus_buffer
    import trk_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         trk_en,
    input  logic         bus_mode,
    input  logic         as_stb,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic         ds,
    input  logic         rnw,
    input  logic         sel_addr,
    input  logic         sel_wrout,
    input  logic         sel_rdin,
    input  logic [W-1:0] bus_in,
    input  logic [W-1:0] port_in,
    output logic [W-1:0] port_out,
    output logic         port_oe,
    output logic [W-1:0] bus_out,
    output logic         bus_oe
);

    trk_cyc_t cyc;
    trk_ctl_t ctl;

    trk_cycle_qual u_qual (
        .bus_mode (bus_mode),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .ds       (ds),
        .rnw      (rnw),
        .cyc      (cyc)
    );

    trk_dir_arb u_arb (
        .trk_en    (trk_en),
        .as_stb    (as_stb),
        .cyc       (cyc),
        .sel_addr  (sel_addr),
        .sel_wrout (sel_wrout),
        .sel_rdin  (sel_rdin),
        .ctl       (ctl)
    );

    trk_data_path #(.W(W)) u_dp (
        .drive_port (ctl.drive_port),
        .drive_bus  (ctl.drive_bus),
        .bus_in     (bus_in),
        .port_in    (port_in),
        .port_out   (port_out),
        .bus_out    (bus_out)
    );

    assign port_oe = ctl.drive_port;
    assign bus_oe  = ctl.drive_bus;

endmodule

// File: rtl/trk_bus_buffer_chk.sv
module trk_bus_buffer_chk #(
    parameter int W = 8
) (
    input logic         trk_en,
    input logic         bus_mode,
    input logic         as_stb,
    input logic         rd_n,
    input logic         ds,
    input logic         rnw,
    input logic         sel_addr,
    input logic         sel_rdin,
    input logic [W-1:0] bus_in,
    input logic [W-1:0] port_in,
    input logic [W-1:0] port_out,
    input logic         port_oe,
    input logic [W-1:0] bus_out,
    input logic         bus_oe
);

    logic rd_seen;
    assign rd_seen = bus_mode ? (ds & rnw) : ~rd_n;

    always_comb begin
        // R8
        oe_exclusive_chk: assert (!(port_oe === 1'b1 && bus_oe === 1'b1))
            else $error("both buffer enables high");
        // R7
        if (trk_en === 1'b0) begin
            disabled_quiet_chk: assert (port_oe !== 1'b1 && bus_oe !== 1'b1)
                else $error("enable high while track mode off");
        end
        // R1
        if (trk_en === 1'b1 && sel_addr === 1'b1 && as_stb === 1'b1) begin
            addr_out_chk: assert (port_oe === 1'b1 && port_out === bus_in)
                else $error("address not driven onto port");
        end
        // R2
        if (trk_en === 1'b1 && sel_rdin === 1'b1 && rd_seen === 1'b1 &&
            !(sel_addr === 1'b1 && as_stb === 1'b1)) begin
            read_in_chk: assert (bus_oe === 1'b1 && bus_out === port_in)
                else $error("port data not driven onto bus");
        end
        // R6
        if (port_oe === 1'b0 && bus_oe === 1'b0) begin
            idle_zero_chk: assert (port_out === '0 && bus_out === '0)
                else $error("drive value nonzero while idle");
        end
    end

endmodule

bind trk_bus_buffer trk_bus_buffer_chk #(.W(W)) u_chk (
    .trk_en   (trk_en),
    .bus_mode (bus_mode),
    .as_stb   (as_stb),
    .rd_n     (rd_n),
    .ds       (ds),
    .rnw      (rnw),
    .sel_addr (sel_addr),
    .sel_rdin (sel_rdin),
    .bus_in   (bus_in),
    .port_in  (port_in),
    .port_out (port_out),
    .port_oe  (port_oe),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe)
);

// File: tb/trk_bus_buffer_bench.sv
module trk_bus_buffer_bench;

    localparam int W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         trk_en, bus_mode, as_stb, rd_n, wr_n, ds, rnw;
    logic         sel_addr, sel_wrout, sel_rdin;
    logic [W-1:0] bus_in, port_in, port_out, bus_out;
    logic         port_oe, bus_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    trk_bus_buffer #(.W(W)) u_trk_bus_buffer (
        .trk_en(trk_en), .bus_mode(bus_mode), .as_stb(as_stb),
        .rd_n(rd_n), .wr_n(wr_n), .ds(ds), .rnw(rnw),
        .sel_addr(sel_addr), .sel_wrout(sel_wrout), .sel_rdin(sel_rdin),
        .bus_in(bus_in), .port_in(port_in),
        .port_out(port_out), .port_oe(port_oe),
        .bus_out(bus_out), .bus_oe(bus_oe)
    );

    // ctl bit order: {trk_en,bus_mode,as_stb,rd_n,wr_n,ds,rnw,sel_addr,sel_wrout,sel_rdin}
    task automatic drive(input logic [9:0] c, input logic [W-1:0] b, input logic [W-1:0] p);
        @(posedge clk);
        {trk_en, bus_mode, as_stb, rd_n, wr_n, ds, rnw, sel_addr, sel_wrout, sel_rdin} = c;
        bus_in  = b;
        port_in = p;
        @(negedge clk);
    endtask

    task automatic compare(input string req, input logic exp_poe, input logic [W-1:0] exp_pout,
                           input logic exp_boe, input logic [W-1:0] exp_bout);
        n_vec++;
        if (port_oe !== exp_poe || port_out !== exp_pout ||
            bus_oe !== exp_boe || bus_out !== exp_bout) begin
            n_bad++;
            $display("FAIL %s: got poe=%b pout=%h boe=%b bout=%h, want poe=%b pout=%h boe=%b bout=%h",
                     req, port_oe, port_out, bus_oe, bus_out, exp_poe, exp_pout, exp_boe, exp_bout);
        end
    endtask

    // Expected outputs from the requirements; returns requirement tag of the case.
    task automatic check_model(input string ctx);
        logic rdc, wrc, a, r, w;
        string tag;
        rdc = bus_mode ? (ds & rnw) : ~rd_n;             // R4
        wrc = bus_mode ? (ds & ~rnw) : ~wr_n;            // R4
        a = trk_en & sel_addr & as_stb;                  // R1
        r = trk_en & ~a & sel_rdin & rdc;                // R2, R5
        w = trk_en & ~a & ~r & sel_wrout & wrc;          // R3, R5
        if (!trk_en)  tag = "R7";
        else if (a)   tag = "R1";
        else if (r)   tag = "R2";
        else if (w)   tag = "R3";
        else          tag = "R6";
        compare({ctx, " ", tag}, a | w, (a | w) ? bus_in : '0, r, r ? port_in : '0);
    endtask

    task automatic t_disabled;   // R7
        drive(10'b0_0_1_0_0_1_1_1_1_1, 8'hA5, 8'h5A);
        compare("R7 disabled", 1'b0, '0, 1'b0, '0);
    endtask

    task automatic t_addr;       // R1
        drive(10'b1_0_1_1_1_0_0_1_0_0, 8'h3C, 8'hC3);
        compare("R1 address out", 1'b1, 8'h3C, 1'b0, '0);
    endtask

    task automatic t_sep_rw;     // R2 R3
        drive(10'b1_0_0_0_1_0_0_0_0_1, 8'h11, 8'hE7);
        compare("R2 separate read", 1'b0, '0, 1'b1, 8'hE7);
        drive(10'b1_0_0_1_0_0_0_0_1_0, 8'h96, 8'h00);
        compare("R3 separate write", 1'b1, 8'h96, 1'b0, '0);
    endtask

    task automatic t_combined;   // R4
        drive(10'b1_1_0_1_1_1_1_0_0_1, 8'h00, 8'hB2);
        compare("R4 combined read", 1'b0, '0, 1'b1, 8'hB2);
        drive(10'b1_1_0_1_1_1_0_0_1_0, 8'h4D, 8'hFF);
        compare("R4 combined write", 1'b1, 8'h4D, 1'b0, '0);
        drive(10'b1_1_0_0_0_0_1_0_1_1, 8'h4D, 8'hFF);
        compare("R4 rd_n/wr_n ignored in combined", 1'b0, '0, 1'b0, '0);
        drive(10'b1_0_0_1_1_1_1_0_1_1, 8'h4D, 8'hFF);
        compare("R4 ds/rnw ignored in separate", 1'b0, '0, 1'b0, '0);
    endtask

    task automatic t_priority;   // R5 R8
        drive(10'b1_0_1_0_0_0_0_1_1_1, 8'h77, 8'h88);
        compare("R5 addr over read/write", 1'b1, 8'h77, 1'b0, '0);
        drive(10'b1_0_0_0_0_0_0_1_1_1, 8'h77, 8'h88);
        compare("R5 read over write", 1'b0, '0, 1'b1, 8'h88);
    endtask

    task automatic t_idle;       // R6
        drive(10'b1_0_1_1_1_0_0_0_1_1, 8'hFF, 8'hFF);
        compare("R6 idle", 1'b0, '0, 1'b0, '0);
    endtask

    task automatic t_sweep;      // R1..R8 exhaustive, R9 repeat
        for (int pat = 0; pat < 2; pat++) begin
            for (int c = 0; c < 1024; c++) begin
                drive(10'(c), pat ? 8'hC9 : 8'h36, pat ? 8'h5E : 8'hA1);
                check_model("sweep");
                n_vec++;
                if (port_oe === 1'b1 && bus_oe === 1'b1) begin
                    n_bad++;
                    $display("FAIL R8: both enables high, got 11 expected not both");
                end
            end
        end
        drive(10'b1_0_0_0_1_0_0_0_0_1, 8'h11, 8'hE7);
        compare("R9 repeat vector", 1'b0, '0, 1'b1, 8'hE7);
    endtask

    initial begin
        {trk_en, bus_mode, as_stb, rd_n, wr_n, ds, rnw, sel_addr, sel_wrout, sel_rdin} = '0;
        bus_in  = '0;
        port_in = '0;
        @(negedge clk);
        compare("R7 initial state", 1'b0, '0, 1'b0, '0);
        t_disabled();
        t_addr();
        t_sep_rw();
        t_combined();
        t_priority();
        t_idle();
        t_sweep();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule